// File: doc/BRIEF.md
# Deferred Payload Merge FIFO

Some commands carry a data phase that shows up well after the command itself. This block handles the write side of a single-ported trace memory for those commands. A command is written into its memory entry in the cycle it is presented, with the deferred field forced to zero. The data beats for that command come later, in the same order as the commands. The block ORs their byte masks into one value. When the last beat arrives, that value is merged into the same entry through a partial write that touches only the deferred field bits.

Command writes always own the memory port. A completed deferred result is written in its completion cycle when the port is free and nothing is waiting. Otherwise it waits in a four-deep ring. The ring drains one element per cycle, and only in cycles without a command write. If the ring is full and cannot drain, a new result replaces the oldest waiting one. The entry that loses its result keeps zeros in its deferred field.

Top module: `dmf_merge`

## Requirements
- R1: After reset, no memory write is issued until an input asks for one, and the ring is empty, so the first completed result is written in its own completion cycle.
- R2: A cycle with `cmd_valid` high writes `cmd_data` to `cmd_idx` in that same cycle, with every bit enable set and the deferred field (bits 15:8 of the entry) forced to zero.
- R3: The deferred result is the OR of `beat_mask` over every beat of one command that has `beat_valid` high, up to and including the beat with `beat_last` high. Cycles with `beat_valid` low add nothing, and the next command's accumulation starts from zero.
- R4: When a result completes in a cycle that has no command write and an empty ring, it is written to `beat_idx` in that same cycle.
- R5: A result that completes in a command-write cycle is queued. The ring never drains in a cycle that has a command write.
- R6: Queued results are written oldest first, one per cycle without a command write.
- R7: Every deferred write has bit enables set only on bits 15:8, carries the result in bits 15:8 and has all other data bits zero.
- R8: A result that arrives while the ring holds four elements and cannot drain replaces the oldest element, which is never written.
- R9: A result that completes while the ring is draining is queued behind the older elements and does not bypass them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command-phase write request; highest priority |
| cmd_idx | input | 6 | Memory entry for the command |
| cmd_data | input | 32 | Command entry contents; deferred bits are ignored |
| beat_valid | input | 1 | A data beat is present |
| beat_last | input | 1 | This beat ends the data phase of its command |
| beat_idx | input | 6 | Memory entry of the command the beat belongs to |
| beat_mask | input | 8 | Byte mask carried by the beat |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 6 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_wbe | output | 32 | Per-bit write enables |

## Verification
The bench targets four corner cases. The first is a completion that coincides with a command write. A design that got this wrong would drop the result or let it take the port. The second is a burst of five queued results with no free cycle. A wrong design would keep the newest-but-one, write the oldest, or write a fifth phantom entry. The third is a completion that arrives while older results are draining. A wrong design would bypass them and reorder the writes. The fourth is a data phase with idle gaps. A wrong design would OR in masks from invalid cycles or carry the accumulated mask into the next command. Random traffic with a fixed seed then mixes all of these and is checked cycle by cycle against a queue model.

// File: rtl/dmf_pkg.sv
// Shared types for the deferred payload merge block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dmf_pkg;

    // Which requester owns the memory port in a cycle.
    typedef enum logic [1:0] {
        GNT_IDLE,
        GNT_CMD,
        GNT_BYPASS,
        GNT_DRAIN
    } grant_e;

endpackage

// File: rtl/dmf_accum.sv
// Accumulates the byte masks of one command's data phase.
// Assumes beats of one command are contiguous (in-order data phases).
// The completed value is presented combinationally in the last-beat cycle.
module dmf_accum #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              beat_last,
    input  logic [MASK_W-1:0] beat_mask,
    output logic              done_valid,
    output logic [MASK_W-1:0] done_mask
);

    logic [MASK_W-1:0] acc_q;

    // Hold the running OR; restart from zero after the closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (beat_valid)
            acc_q <= beat_last ? '0 : (acc_q | beat_mask);
    end

    // Completed result includes the closing beat's mask.
    always_comb begin
        done_valid = beat_valid && beat_last;
        done_mask  = acc_q | beat_mask;
    end

    assert_acc_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last) |=> (acc_q == '0));

    assert_idle_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> $stable(acc_q));

endmodule

// File: rtl/dmf_ring.sv
// Shallow ring of pending deferred results that overwrites its oldest
// element when pushed while full without a pop in the same cycle.
// Assumes pop is only raised by the port owner in a free cycle.
module dmf_ring #(
    parameter int DEPTH  = 4,
    parameter int ELEM_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ELEM_W-1:0] push_data,
    input  logic              pop,
    output logic [ELEM_W-1:0] head,
    output logic              empty,
    output logic              full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [ELEM_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop_ok, overwrite, grow;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // Derive occupancy flags and this cycle's pointer actions.
    always_comb begin
        empty     = (cnt_q == '0);
        full      = (cnt_q == FULL_CNT);
        head      = slots[rd_q];
        pop_ok    = pop && !empty;
        overwrite = push && full && !pop_ok;
        grow      = push && !overwrite;
    end

    // Store pushed elements; storage needs no reset.
    always_ff @(posedge clk) begin
        if (push)
            slots[wr_q] <= push_data;
    end

    // Advance pointers and occupancy; overwrite drops the oldest slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push)
                wr_q <= bump(wr_q);
            if (pop_ok || overwrite)
                rd_q <= bump(rd_q);
            if (grow && !pop_ok)
                cnt_q <= cnt_q + 1'b1;
            else if (!grow && pop_ok)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_overwrite_stays_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);

    assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);

endmodule

// File: rtl/dmf_arbiter.sv
// Owns the single memory write port: command writes first, then either a
// same-cycle bypass (ring empty) or a drain of the ring head.
// Assumes the ring head is valid whenever fifo_empty is low.
module dmf_arbiter
    import dmf_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int ENTRY_W = 32,
    parameter int MASK_W  = 8,
    parameter int FLD_LSB = 8
) (
    input  logic               cmd_valid,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [ENTRY_W-1:0] cmd_data,
    input  logic               done_valid,
    input  logic [IDX_W-1:0]   done_idx,
    input  logic [MASK_W-1:0]  done_mask,
    input  logic               fifo_empty,
    input  logic [IDX_W-1:0]   head_idx,
    input  logic [MASK_W-1:0]  head_mask,
    output logic               fifo_push,
    output logic               fifo_pop,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic [ENTRY_W-1:0] mem_wbe
);

    localparam logic [ENTRY_W-1:0] FLD_BITS = ENTRY_W'({MASK_W{1'b1}}) << FLD_LSB;

    grant_e gnt;

    // Pick the port owner for this cycle.
    always_comb begin
        if (cmd_valid)
            gnt = GNT_CMD;
        else if (done_valid && fifo_empty)
            gnt = GNT_BYPASS;
        else if (!fifo_empty)
            gnt = GNT_DRAIN;
        else
            gnt = GNT_IDLE;
    end

    // Drive the port and the ring controls from the grant.
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wbe   = '0;
        fifo_pop  = 1'b0;
        fifo_push = 1'b0;
        unique case (gnt)
            GNT_CMD: begin
                mem_we    = 1'b1;
                mem_addr  = cmd_idx;
                mem_wdata = cmd_data & ~FLD_BITS;
                mem_wbe   = '1;
                fifo_push = done_valid;
            end
            GNT_BYPASS: begin
                mem_we    = 1'b1;
                mem_addr  = done_idx;
                mem_wdata = ENTRY_W'(done_mask) << FLD_LSB;
                mem_wbe   = FLD_BITS;
            end
            GNT_DRAIN: begin
                mem_we    = 1'b1;
                mem_addr  = head_idx;
                mem_wdata = ENTRY_W'(head_mask) << FLD_LSB;
                mem_wbe   = FLD_BITS;
                fifo_pop  = 1'b1;
                fifo_push = done_valid;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dmf_merge.sv
// Deferred payload merge: writes command entries at once with the deferred
// field cleared, accumulates data-phase masks, and merges each result back
// into its entry through a partial write, directly or via a shallow ring.
// Assumes data phases arrive in command order and beat_idx names the entry.
module dmf_merge #(
    parameter int IDX_W   = 6,
    parameter int ENTRY_W = 32,
    parameter int MASK_W  = 8,
    parameter int FLD_LSB = 8,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [ENTRY_W-1:0] cmd_data,
    input  logic               beat_valid,
    input  logic               beat_last,
    input  logic [IDX_W-1:0]   beat_idx,
    input  logic [MASK_W-1:0]  beat_mask,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic [ENTRY_W-1:0] mem_wbe
);

    localparam int ELEM_W = IDX_W + MASK_W;
    localparam logic [ENTRY_W-1:0] FLD_BITS = ENTRY_W'({MASK_W{1'b1}}) << FLD_LSB;

    logic              done_valid;
    logic [MASK_W-1:0] done_mask;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [ELEM_W-1:0] fifo_head;

    dmf_accum #(.MASK_W(MASK_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .beat_mask  (beat_mask),
        .done_valid (done_valid),
        .done_mask  (done_mask)
    );

    dmf_ring #(.DEPTH(DEPTH), .ELEM_W(ELEM_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data ({beat_idx, done_mask}),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    dmf_arbiter #(
        .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .MASK_W(MASK_W), .FLD_LSB(FLD_LSB)
    ) u_arb (
        .cmd_valid  (cmd_valid),
        .cmd_idx    (cmd_idx),
        .cmd_data   (cmd_data),
        .done_valid (done_valid),
        .done_idx   (beat_idx),
        .done_mask  (done_mask),
        .fifo_empty (fifo_empty),
        .head_idx   (fifo_head[ELEM_W-1:MASK_W]),
        .head_mask  (fifo_head[MASK_W-1:0]),
        .fifo_push  (fifo_push),
        .fifo_pop   (fifo_pop),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_wbe    (mem_wbe)
    );

    assert_cmd_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (mem_we && mem_addr == cmd_idx && mem_wbe == '1
                       && (mem_wdata & FLD_BITS) == '0));

    assert_bypass_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !cmd_valid && fifo_empty) |-> (mem_we && mem_addr == beat_idx));

    assert_partial_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !cmd_valid) |-> (mem_wbe == FLD_BITS && (mem_wdata & ~FLD_BITS) == '0));

    assert_no_drain_under_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !fifo_empty) |=> !fifo_empty);

    assert_full_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

endmodule

// File: tb/dmf_merge_bench.sv
module dmf_merge_bench;

    localparam int IDX_W = 6;
    localparam int ENTRY_W = 32;
    localparam int MASK_W = 8;
    localparam int FLD_LSB = 8;
    localparam int DEPTH = 4;
    localparam logic [ENTRY_W-1:0] FLD = 32'h0000_FF00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [IDX_W-1:0] cmd_idx = '0;
    logic [ENTRY_W-1:0] cmd_data = '0;
    logic beat_valid = 1'b0;
    logic beat_last = 1'b0;
    logic [IDX_W-1:0] beat_idx = '0;
    logic [MASK_W-1:0] beat_mask = '0;
    logic mem_we;
    logic [IDX_W-1:0] mem_addr;
    logic [ENTRY_W-1:0] mem_wdata, mem_wbe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model state
    logic [MASK_W-1:0] m_acc = '0;
    logic [IDX_W-1:0]  q_idx[$];
    logic [MASK_W-1:0] q_msk[$];

    always #2 clk = ~clk;

    dmf_merge #(
        .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .MASK_W(MASK_W),
        .FLD_LSB(FLD_LSB), .DEPTH(DEPTH)
    ) u_dmf_merge (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
        .beat_valid(beat_valid), .beat_last(beat_last),
        .beat_idx(beat_idx), .beat_mask(beat_mask),
        .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wbe(mem_wbe)
    );

    // Drive one cycle, check the port against the model, then advance the model.
    task automatic step(input bit cv, input logic [IDX_W-1:0] ci, input logic [ENTRY_W-1:0] cd,
                        input bit bv, input bit bl, input logic [IDX_W-1:0] bi,
                        input logic [MASK_W-1:0] bm, input string tag);
        bit done;
        logic [MASK_W-1:0] dm;
        bit ewe;
        logic [IDX_W-1:0] ea;
        logic [ENTRY_W-1:0] ed, eb;
        string t;
        @(negedge clk);
        cmd_valid = cv; cmd_idx = ci; cmd_data = cd;
        beat_valid = bv; beat_last = bl; beat_idx = bi; beat_mask = bm;
        #1;
        done = bv && bl;
        dm = m_acc | bm;
        ewe = 1'b0; ea = '0; ed = '0; eb = '0;
        if (cv) begin
            ewe = 1'b1; ea = ci; ed = cd & ~FLD; eb = '1; t = "R2";
            if (done) begin q_idx.push_back(bi); q_msk.push_back(dm); end
        end else if (done && q_idx.size() == 0) begin
            ewe = 1'b1; ea = bi; ed = {16'h0, dm, 8'h0}; eb = FLD; t = "R4";
        end else if (q_idx.size() > 0) begin
            ewe = 1'b1; ea = q_idx.pop_front(); ed = {16'h0, q_msk.pop_front(), 8'h0};
            eb = FLD; t = "R6";
            if (done) begin q_idx.push_back(bi); q_msk.push_back(dm); end
        end else begin
            t = "R5";
        end
        if (q_idx.size() > DEPTH) begin
            void'(q_idx.pop_front());
            void'(q_msk.pop_front());
        end
        if (bv) m_acc = bl ? '0 : dm;
        if (tag != "") t = tag;
        total++;
        if (mem_we !== ewe || (ewe && (mem_addr !== ea || mem_wdata !== ed || mem_wbe !== eb))) begin
            bad++;
            $display("FAIL %s: we=%0b addr=%0d data=%h be=%h expected we=%0b addr=%0d data=%h be=%h",
                     t, mem_we, mem_addr, mem_wdata, mem_wbe, ewe, ea, ed, eb);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: no write during reset
        repeat (3) @(negedge clk);
        #1;
        total++;
        if (mem_we !== 1'b0) begin
            bad++;
            $display("FAIL R1: we=%0b expected 0", mem_we);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R1: first completion bypasses, proving the ring is empty
        step(0, 0, 0, 1, 1, 6'd9, 8'h5A, "R1");

        // R3: beats with a gap and a masked invalid beat
        step(0, 0, 0, 1, 0, 6'd5, 8'h01, "R3");
        step(0, 0, 0, 0, 0, 6'd5, 8'h80, "R3");
        step(0, 0, 0, 1, 0, 6'd5, 8'h10, "R3");
        step(0, 0, 0, 1, 1, 6'd5, 8'h02, "R3");  // expect 0x13 at entry 5, R7 bit enables
        step(0, 0, 0, 1, 1, 6'd6, 8'h04, "R3");  // fresh start: 0x04 only

        // R5: completion under a command is queued, then drained
        step(1, 6'd7, 32'hDEAD_BEEF, 1, 1, 6'd3, 8'h33, "R5");
        step(0, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 0, "R5");

        // R8: five results under commands; the first is lost
        for (int k = 1; k <= 5; k++)
            step(1, 6'(k + 20), 32'hFFFF_FFFF, 1, 1, 6'(k), 8'(1 << k), "R8");
        for (int k = 0; k < 5; k++)
            step(0, 0, 0, 0, 0, 0, 0, "R8");

        // R9: completion while draining is queued behind older results
        step(1, 6'd40, 32'h1234_5678, 1, 1, 6'd11, 8'hA1, "R9");
        step(1, 6'd41, 32'h8765_4321, 1, 1, 6'd12, 8'hA2, "R9");
        step(0, 0, 0, 1, 1, 6'd13, 8'hA3, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");

        // Random mix, tags chosen per cycle by the model (R2/R4/R5/R6)
        for (int n = 0; n < 800; n++) begin
            step(($urandom % 3) == 0, 6'($urandom), $urandom,
                 ($urandom % 2) == 0, ($urandom % 3) == 0, 6'($urandom), 8'($urandom), "");
        end
        for (int n = 0; n < 8; n++)
            step(0, 0, 0, 0, 0, 0, 0, "");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule